// File: doc/BRIEF.md
# Oversampling Serial Bit Recovery

This block takes a slow serial line that comes from a remote board with its own crystal. It recovers the bits on that line using only the local fast clock. The line is oversampled at about eight fast-clock cycles per bit. The block passes the line through a synchronizer and watches for level changes. After each change it counts forward to the middle of the bit and takes one sample there. Each recovered bit appears together with a strobe that is one cycle wide, so the logic downstream stays in the fast clock domain. The block never creates a derived clock.

The line code guarantees a transition often enough that the sample point is pulled back to the bit centre regularly. Between transitions, a free-running phase count keeps taking one sample every eight cycles, so a run of equal bits still produces one sample per bit. The two crystals drift slowly against each other. A four-slot elastic buffer between the sampler and the consumer absorbs this drift. A consumer read that finds the buffer empty, or a sample that finds it full, leaves a sticky flag behind.

Top module: `serial_bit_recovery`

## Requirements
- R1: When the line changes level, the sample strobe `samp_ce` becomes high in the cycle after the 7th rising clock edge. The 1st edge is the first one that sees the new level. The delay is made of two synchronizer stages, one edge-detect register and a mid-bit sample point at phase 4 of an 8-cycle bit.
- R2: After reset, `samp_ce` stays low until the line shows its first transition, however long the line stays idle.
- R3: `samp_ce` is high for one cycle only. While the line has no transition, the strobe repeats exactly every 8 cycles.
- R4: A transition that comes earlier than the phase count expects restarts the phase count. The next strobe then follows the R1 delay measured from this new transition, and the strobe that was due from the old phase is not produced.
- R5: `samp_bit` holds the synchronized line level at the sample point. Each bit may last 7, 8 or 9 cycles, with at most one bit that is not 8 cycles long in each run of equal bits, and a run is at most 5 bits long. For such a stream, every sent bit is recovered once, in the order it was sent.
- R6: The buffer holds up to 4 bits and returns them in the order they were written. If `rd_en` is high at a rising edge and the buffer is not empty, then `rx_valid` is high in the next cycle and `rx_bit` carries the oldest stored bit. Otherwise `rx_valid` is low in the next cycle.
- R7: If a sample arrives while the buffer holds 4 bits and no read happens in the same cycle, that sample is dropped and `ovf_flag` is set. The flag stays set until reset. A read in the same cycle makes room for the sample.
- R8: A read while the buffer is empty returns no data, so `rx_valid` is low. It also sets `udf_flag`, which stays set until reset.
- R9: Reset is synchronous and active high. It empties the buffer, clears both flags, and drives `samp_ce` and `rx_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock (about 8 cycles per line bit) |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Asynchronous serial line |
| rd_en | input | 1 | Consumer read request for one buffered bit |
| samp_ce | output | 1 | One-cycle strobe, one for each recovered bit |
| samp_bit | output | 1 | Recovered bit, valid while `samp_ce` is high |
| rx_bit | output | 1 | Bit read out of the elastic buffer |
| rx_valid | output | 1 | `rx_bit` holds a bit read in the previous cycle |
| ovf_flag | output | 1 | Sticky flag: a sample was dropped because the buffer was full |
| udf_flag | output | 1 | Sticky flag: a read was made while the buffer was empty |

## Verification
Directed cases target the exact strobe latency after a transition, and a strobe that is produced before the first transition, which is what an unarmed counter would do. They also cover the 8-cycle repeat on a held level and a transition that lands just before the old phase would have sampled. A design that did not re-phase would emit an extra strobe in that last case. A random stream mixes 7-, 8- and 9-cycle bits under run-length limits. It finds a sample point set too close to a bit edge, because that causes bits to be lost or counted twice. Random reads run against a reference model of the buffer. They show wrong ordering, a full buffer that overwrites instead of dropping, a read that claims data from an empty buffer, and flags that clear on their own.

// File: rtl/osr_pkg.sv
package osr_pkg;

    localparam int OVS_DEFAULT        = 8;
    localparam int SAMPLE_AT_DEFAULT  = 4;
    localparam int FIFO_DEPTH_DEFAULT = 4;
    localparam int SYNC_DEFAULT       = 2;

    // One recovered bit together with its strobe
    typedef struct packed {
        logic vld;
        logic dat;
    } bitbeat_t;

    // Phase tracker: waiting for the first transition, or tracking
    typedef enum logic {
        TRK_WAIT = 1'b0,
        TRK_RUN  = 1'b1
    } trk_state_e;

    // Modulo increment, used for phase counters and buffer pointers
    function automatic int wrap_next(input int v, input int lim);
        return (v >= lim - 1) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/osr_line_sync.sv
module osr_line_sync #(
    parameter int STAGES = osr_pkg::SYNC_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic edge_det
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], din};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= din;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[STAGES-1];
    end

    assign level    = chain_q[STAGES-1];
    assign edge_det = level ^ prev_q;

endmodule

// File: rtl/osr_phase_track.sv
module osr_phase_track
    import osr_pkg::*;
#(
    parameter int OVS       = OVS_DEFAULT,
    parameter int SAMPLE_AT = SAMPLE_AT_DEFAULT
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     level,
    input  logic     edge_det,
    output bitbeat_t beat
);
    localparam int PH_W = (OVS > 1) ? $clog2(OVS) : 1;

    trk_state_e      state_q;
    logic [PH_W-1:0] cnt_q;
    logic [PH_W-1:0] phase_now;
    logic            live_now;

    // An edge restarts the phase at zero in the cycle where it is seen
    assign phase_now = edge_det ? '0 : cnt_q;
    assign live_now  = (state_q == TRK_RUN) || edge_det;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TRK_WAIT;
            cnt_q   <= '0;
            beat    <= '0;
        end else begin
            if (edge_det) state_q <= TRK_RUN;
            cnt_q    <= PH_W'(wrap_next(int'(phase_now), OVS));
            beat.vld <= live_now && (phase_now == PH_W'(SAMPLE_AT));
            beat.dat <= level;
        end
    end

    // R2: nothing is sampled before the first transition
    a_r2_quiet_until_edge: assert property (@(posedge clk) disable iff (rst)
        (state_q == TRK_WAIT && !edge_det) |=> !beat.vld)
        else $error("strobe before first transition");

    // R3: strobe is a single-cycle pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        beat.vld |=> !beat.vld)
        else $error("strobe wider than one cycle");

    // R4: a transition suppresses the strobe in the following cycle
    a_r4_rephase: assert property (@(posedge clk) disable iff (rst)
        (edge_det && SAMPLE_AT != 0) |=> !beat.vld)
        else $error("strobe right after re-phasing edge");

endmodule

// File: rtl/osr_elastic.sv
module osr_elastic
    import osr_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH_DEFAULT
) (
    input  logic     clk,
    input  logic     rst,
    input  bitbeat_t wr,
    input  logic     rd_en,
    output logic     rx_bit,
    output logic     rx_valid,
    output logic     ovf,
    output logic     udf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    logic [DEPTH-1:0] mem_q;
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             empty, full, rd_ok, wr_ok;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign rd_ok = rd_en && !empty;
    assign wr_ok = wr.vld && (!full || rd_ok);

    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[wp_q] <= wr.dat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q     <= '0;
            rp_q     <= '0;
            cnt_q    <= '0;
            rx_bit   <= 1'b0;
            rx_valid <= 1'b0;
            ovf      <= 1'b0;
            udf      <= 1'b0;
        end else begin
            if (wr_ok) wp_q <= PTR_W'(wrap_next(int'(wp_q), DEPTH));
            if (rd_ok) begin
                rp_q   <= PTR_W'(wrap_next(int'(rp_q), DEPTH));
                rx_bit <= mem_q[rp_q];
            end
            rx_valid <= rd_ok;
            case ({wr_ok, rd_ok})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
            if (wr.vld && !wr_ok) ovf <= 1'b1;
            if (rd_en && empty)   udf <= 1'b1;
        end
    end

    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH))
        else $error("occupancy above depth");

    a_r7_drop_when_full: assert property (@(posedge clk) disable iff (rst)
        (wr.vld && full && !rd_en) |=> (ovf && full))
        else $error("full buffer did not drop sample");

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf)
        else $error("overflow flag cleared");

    a_r8_empty_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty) |=> (!rx_valid && udf))
        else $error("empty read produced data");

    a_r8_udf_sticky: assert property (@(posedge clk) disable iff (rst)
        udf |=> udf)
        else $error("underflow flag cleared");

endmodule

// File: rtl/serial_bit_recovery.sv
module serial_bit_recovery
    import osr_pkg::*;
#(
    parameter int OVS         = OVS_DEFAULT,
    parameter int SAMPLE_AT   = SAMPLE_AT_DEFAULT,
    parameter int FIFO_DEPTH  = FIFO_DEPTH_DEFAULT,
    parameter int SYNC_STAGES = SYNC_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic rd_en,
    output logic samp_ce,
    output logic samp_bit,
    output logic rx_bit,
    output logic rx_valid,
    output logic ovf_flag,
    output logic udf_flag
);
    logic     lvl, edg;
    bitbeat_t beat;

    osr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(line_in), .level(lvl), .edge_det(edg)
    );

    osr_phase_track #(.OVS(OVS), .SAMPLE_AT(SAMPLE_AT)) u_track (
        .clk(clk), .rst(rst), .level(lvl), .edge_det(edg), .beat(beat)
    );

    osr_elastic #(.DEPTH(FIFO_DEPTH)) u_buf (
        .clk(clk), .rst(rst), .wr(beat), .rd_en(rd_en),
        .rx_bit(rx_bit), .rx_valid(rx_valid), .ovf(ovf_flag), .udf(udf_flag)
    );

    assign samp_ce  = beat.vld;
    assign samp_bit = beat.dat;

    // R9: first cycle after reset shows idle outputs
    a_r9_reset_idle: assert property (@(posedge clk)
        $fell(rst) |-> (!samp_ce && !rx_valid && !ovf_flag && !udf_flag))
        else $error("outputs not idle after reset");

endmodule

// File: tb/serial_bit_recovery_test.sv
`timescale 1ns/1ps
module serial_bit_recovery_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_in = 1'b0;
    logic rd_en = 1'b0;
    logic samp_ce, samp_bit, rx_bit, rx_valid, ovf_flag, udf_flag;

    always #2.5 clk = ~clk;

    serial_bit_recovery uut (
        .clk(clk), .rst(rst), .line_in(line_in), .rd_en(rd_en),
        .samp_ce(samp_ce), .samp_bit(samp_bit), .rx_bit(rx_bit),
        .rx_valid(rx_valid), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // buffer reference model
    int mq[$];
    bit exp_valid, exp_bit, exp_ovf, exp_udf;
    // stream reference
    int sq[$];
    bit chk_stream;
    bit prev_ce;
    // stream generator state
    bit g_lvl, g_started, g_irr;
    int g_left, g_run;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic bit gen_step();
        int b, per;
        if (g_left == 0) begin
            if (!g_started) b = 1;
            else if (g_run >= 5) b = g_lvl ? 0 : 1;
            else b = int'($urandom % 2);
            if (g_started && b == int'(g_lvl)) g_run++;
            else begin g_run = 1; g_irr = 0; end
            g_started = 1;
            g_lvl = b[0];
            per = 8;
            if (!g_irr && ($urandom % 4 == 0)) begin
                per = ($urandom % 2 == 0) ? 7 : 9;
                g_irr = 1;
            end
            sq.push_back(b);
            g_left = per;
        end
        g_left--;
        return g_lvl;
    endfunction

    // one clock: drive at negedge, model, advance, check at next negedge
    task automatic cycle(input bit lv, input bit rv);
        bit rd_ok;
        int e;
        line_in = lv;
        rd_en   = rv;
        rd_ok   = rv && (mq.size() > 0);
        if (rd_ok) begin exp_valid = 1; exp_bit = mq.pop_front() != 0; end
        else exp_valid = 0;
        if (rv && !rd_ok) exp_udf = 1;
        if (samp_ce) begin
            if (mq.size() < 4) mq.push_back(int'(samp_bit));
            else exp_ovf = 1;
        end
        @(posedge clk);
        @(negedge clk);
        chk(rx_valid == exp_valid, "R6 rx_valid", int'(rx_valid), int'(exp_valid));
        if (exp_valid) chk(rx_bit == exp_bit, "R6 rx_bit order", int'(rx_bit), int'(exp_bit));
        chk(ovf_flag == exp_ovf, "R7 ovf_flag", int'(ovf_flag), int'(exp_ovf));
        chk(udf_flag == exp_udf, "R8 udf_flag", int'(udf_flag), int'(exp_udf));
        if (samp_ce && prev_ce) chk(0, "R3 strobe width", 2, 1);
        if (samp_ce && chk_stream) begin
            if (sq.size() == 0) chk(0, "R5 extra sample", 1, 0);
            else begin
                e = sq.pop_front();
                chk(int'(samp_bit) == e, "R5 recovered bit", int'(samp_bit), e);
            end
        end
        prev_ce = samp_ce;
    endtask

    task automatic do_reset();
        rst = 1; line_in = 0; rd_en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        mq.delete(); sq.delete();
        exp_valid = 0; exp_bit = 0; exp_ovf = 0; exp_udf = 0;
        g_lvl = 0; g_started = 0; g_irr = 0; g_left = 0; g_run = 0;
        chk_stream = 0; prev_ce = 0;
        @(posedge clk); @(negedge clk);
        chk(samp_ce == 0 && rx_valid == 0, "R9 reset outputs", int'(samp_ce | rx_valid), 0);
        chk(ovf_flag == 0 && udf_flag == 0, "R9 reset flags", int'(ovf_flag | udf_flag), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n_ce, first_pos, second_pos, third_pos;
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();

        // R2: idle line, no strobe
        n_ce = 0;
        for (int i = 0; i < 40; i++) begin cycle(0, 0); if (samp_ce) n_ce++; end
        chk(n_ce == 0, "R2 no strobe before edge", n_ce, 0);

        // R1/R3: latency and wrap on held level
        first_pos = 0; second_pos = 0; third_pos = 0;
        for (int i = 1; i <= 19; i++) begin
            cycle(1, 0);
            if (samp_ce) begin
                if (first_pos == 0) first_pos = i;
                else if (second_pos == 0) second_pos = i;
                else third_pos = i;
                chk(samp_bit == 1, "R5 sampled level high", int'(samp_bit), 1);
            end
        end
        chk(first_pos == 7, "R1 first strobe position", first_pos, 7);
        chk(second_pos == 15, "R3 repeat after 8 cycles", second_pos, 15);
        chk(third_pos == 0, "R3 no extra strobe", third_pos, 0);

        // R4: transition before the old phase point re-phases
        first_pos = 0; n_ce = 0;
        for (int i = 1; i <= 10; i++) begin
            cycle(0, 0);
            if (samp_ce) begin
                n_ce++;
                if (first_pos == 0) first_pos = i;
                chk(samp_bit == 0, "R4 sampled new level", int'(samp_bit), 0);
            end
        end
        chk(first_pos == 7, "R4 strobe from new edge", first_pos, 7);
        chk(n_ce == 1, "R4 old phase strobe suppressed", n_ce, 1);

        // R8: empty read
        do_reset();
        cycle(0, 1);
        chk(udf_flag == 1 && rx_valid == 0, "R8 empty read", int'(udf_flag), 1);

        // R7: stream without reads fills and overflows, then drain
        do_reset();
        chk_stream = 1;
        for (int i = 0; i < 80; i++) cycle(gen_step(), 0);
        chk(ovf_flag == 1, "R7 overflow set", int'(ovf_flag), 1);
        for (int i = 0; i < 80; i++) cycle(gen_step(), ($urandom % 3) == 0);

        // R9 after flags set, then long mixed run (R5, R6)
        do_reset();
        chk_stream = 1;
        for (int i = 0; i < 4000; i++) cycle(gen_step(), ($urandom % 4) == 0);
        for (int i = 0; i < 200; i++) cycle(gen_step(), ($urandom % 2) == 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule